// File: doc/BRIEF.md
# Dual-Clock Pixel FIFO with Underflow Protection

This block moves pixel words from a video write clock domain into a stream read clock domain. It has 32 entries by default. Each pointer has one revolution bit above its address bits. It is passed across the boundary in Gray code through a two-flop synchronizer and turned back into binary on the far side. Full is decoded on the write side and empty on the read side. The read side also reports a fill level and whether that level meets a minimum cushion. Synchronized pointers lag the true values, so the reader should keep a few entries in hand to avoid visible artifacts.

The write side is valid/ready. `wr_ready` drops while the FIFO is full. A word offered with `wr_valid` while `wr_ready` is low is thrown away, and it sets a sticky overflow flag. The read side takes no back-pressure from the block: every cycle in which `rd_ready` is high is a read, and its result appears on the registered outputs one read clock later. A read of a non-empty FIFO loads the next word and marks the beat with `rd_valid`. A read of an empty FIFO is still accepted. It leaves the read pointer and `rd_data` as they were and marks the beat with `rd_err`, so a run of filler reads can push an end-of-line marker through a downstream pipeline. No pixel is lost or repeated. After new data is written, the next good read returns the first new pixel.

Top module: `pxf_fifo`

## Requirements
- R1: After reset, `rd_empty`=1, `rd_level`=0, `rd_cushion_ok`=0, `wr_ready`=1, and `wr_overflow`, `rd_valid` and `rd_err` are 0.
- R2: Every word accepted on the write side (`wr_valid` and `wr_ready` both high at a write clock edge) comes out exactly once, in order, on a beat with `rd_valid`=1.
- R3: A word offered while `wr_ready`=0 is dropped and never read. `wr_overflow` goes to 1 from the next write clock and stays at 1 until reset.
- R4: With no reads, the FIFO accepts exactly 32 words (the default depth). Once the pointers have synchronized, `wr_ready`=0 and `rd_level`=32.
- R5: `rd_empty` goes high in the same cycle that the last available word appears on `rd_data`.
- R6: A read made while `rd_empty`=1 gives a beat with `rd_err`=1 and `rd_valid`=0. `rd_data` keeps its previous value.
- R7: After reads on an empty FIFO, the first good read following new writes returns the first newly written word.
- R8: `rd_level` is 6 bits wide. It equals the synchronized write pointer minus the read pointer, modulo 64, and it never exceeds 32.
- R9: `rd_cushion_ok` is 1 exactly when `rd_level` is at least CUSHION (default 2).
- R10: In a read clock cycle with `rd_ready`=0, the next beat has `rd_valid`=0 and `rd_err`=0, and `rd_data` is unchanged.
- R11: A read made while `rd_empty`=0 gives `rd_valid`=1 and `rd_err`=0 on the next read clock. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write (video) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | Write word offered |
| wr_data | input | DW (8) | Pixel word to write |
| wr_ready | output | 1 | FIFO can accept a word (not full) |
| wr_overflow | output | 1 | Sticky: a word was offered while full |
| rd_clk | input | 1 | Read (stream) clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_ready | input | 1 | Read request for this cycle |
| rd_data | output | DW (8) | Output register |
| rd_valid | output | 1 | Current beat is a real pixel |
| rd_err | output | 1 | Current beat came from a read while empty |
| rd_empty | output | 1 | No unread word is visible to the read side |
| rd_level | output | AW+1 (6) | Read-side fill level |
| rd_cushion_ok | output | 1 | Fill level is at least CUSHION |

## Verification
Randomly interleaved writes and reads on two unrelated clocks, with a fixed seed, check ordering, loss and duplication against a queue model. This stresses how pointer lag interacts with the empty and full decodes. Directed patterns cover the rest. Reads on a freshly reset FIFO test error flagging without any prior data. A single word followed by filler reads separates the output register holding its value from a pointer that wrongly advances. A fill to 32 entries followed by an extra write separates correct full decoding from revolution-bit aliasing, and it shows that the dropped word never appears. Idle cycles check that nothing moves without a read.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
  // number of flops on each clock-crossing pointer path
  localparam int unsigned PXF_SYNC_STAGES = 2;
  // default geometry
  localparam int unsigned PXF_DEF_AW = 5;
  localparam int unsigned PXF_DEF_DW = 8;
endpackage

// File: rtl/pxf_ptr_sync.sv
module pxf_ptr_sync #(
  parameter int unsigned PW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  localparam int unsigned NS = pxf_pkg::PXF_SYNC_STAGES;

  logic [PW-1:0] stg [NS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) stg[i] <= '0;
    end else begin
      stg[0] <= gray_in;
      for (int i = 1; i < NS; i++) stg[i] <= stg[i-1];
    end
  end

  // Gray back to binary: each bit is the xor of all gray bits at or above it
  always_comb begin
    bin_out[PW-1] = stg[NS-1][PW-1];
    for (int i = PW - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ stg[NS-1][i];
  end
endmodule

// File: rtl/pxf_mem.sv
module pxf_mem #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/pxf_wr_ctl.sv
module pxf_wr_ctl #(
  parameter int unsigned AW = 5
) (
  input  logic        wclk,
  input  logic        wrst,
  input  logic        wr_valid,
  input  logic [AW:0] rptr_sync,
  output logic        wr_ready,
  output logic        wr_overflow,
  output logic        mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW:0] wptr_gray
);
  logic [AW:0] wptr;
  logic [AW:0] wptr_nxt;
  logic        full;

  // same address, opposite revolution bit: one full lap ahead
  assign full      = (wptr[AW] != rptr_sync[AW]) && (wptr[AW-1:0] == rptr_sync[AW-1:0]);
  assign wr_ready  = !full;
  assign mem_we    = wr_valid && !full;
  assign mem_waddr = wptr[AW-1:0];
  assign wptr_nxt  = wptr + 1'b1;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wptr        <= '0;
      wptr_gray   <= '0;
      wr_overflow <= 1'b0;
    end else begin
      if (mem_we) begin
        wptr      <= wptr_nxt;
        wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
      end
      if (wr_valid && full) wr_overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/pxf_rd_ctl.sv
module pxf_rd_ctl #(
  parameter int unsigned AW      = 5,
  parameter int unsigned DW      = 8,
  parameter int unsigned CUSHION = 2
) (
  input  logic          rclk,
  input  logic          rrst,
  input  logic          rd_ready,
  input  logic [AW:0]   wptr_sync,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] mem_raddr,
  output logic [AW:0]   rptr_gray,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_err,
  output logic          rd_empty,
  output logic [AW:0]   rd_level,
  output logic          rd_cushion_ok
);
  localparam int unsigned PW = AW + 1;

  logic [AW:0] rptr;
  logic [AW:0] rptr_nxt;
  logic        take;

  assign rd_empty      = (rptr == wptr_sync);
  assign rd_level      = wptr_sync - rptr;
  assign rd_cushion_ok = (rd_level >= PW'(CUSHION));
  assign mem_raddr     = rptr[AW-1:0];
  assign rptr_nxt      = rptr + 1'b1;
  assign take          = rd_ready && !rd_empty;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rptr      <= '0;
      rptr_gray <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      rd_err    <= 1'b0;
    end else begin
      rd_valid <= take;
      rd_err   <= rd_ready && rd_empty;
      if (take) begin
        rd_data   <= mem_q;
        rptr      <= rptr_nxt;
        rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
      end
    end
  end
endmodule

// File: rtl/pxf_fifo.sv
module pxf_fifo #(
  parameter int unsigned AW      = pxf_pkg::PXF_DEF_AW,
  parameter int unsigned DW      = pxf_pkg::PXF_DEF_DW,
  parameter int unsigned CUSHION = 2
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          wr_overflow,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_err,
  output logic          rd_empty,
  output logic [AW:0]   rd_level,
  output logic          rd_cushion_ok
);
  localparam int unsigned PW = AW + 1;

  logic          we;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [DW-1:0] q;
  logic [PW-1:0] wgray;
  logic [PW-1:0] rgray;
  logic [PW-1:0] wsync;
  logic [PW-1:0] rsync;

  pxf_wr_ctl #(.AW(AW)) u_wr (
    .wclk(wr_clk), .wrst(wr_rst), .wr_valid(wr_valid), .rptr_sync(rsync),
    .wr_ready(wr_ready), .wr_overflow(wr_overflow), .mem_we(we),
    .mem_waddr(waddr), .wptr_gray(wgray)
  );

  pxf_mem #(.AW(AW), .DW(DW)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(q)
  );

  pxf_ptr_sync #(.PW(PW)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .gray_in(wgray), .bin_out(wsync)
  );

  pxf_ptr_sync #(.PW(PW)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .gray_in(rgray), .bin_out(rsync)
  );

  pxf_rd_ctl #(.AW(AW), .DW(DW), .CUSHION(CUSHION)) u_rd (
    .rclk(rd_clk), .rrst(rd_rst), .rd_ready(rd_ready), .wptr_sync(wsync),
    .mem_q(q), .mem_raddr(raddr), .rptr_gray(rgray), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_err(rd_err), .rd_empty(rd_empty),
    .rd_level(rd_level), .rd_cushion_ok(rd_cushion_ok)
  );
endmodule

// File: rtl/pxf_fifo_chk.sv
module pxf_fifo_chk #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 8
) (
  input logic          wr_clk,
  input logic          wr_rst,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_overflow,
  input logic          rd_clk,
  input logic          rd_rst,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          rd_err,
  input logic          rd_empty,
  input logic [AW:0]   rd_level
);
  localparam int unsigned DEPTH = 1 << AW;

  AST_LEVEL_RANGE: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_level <= (AW+1)'(DEPTH)); // R8

  AST_BEAT_EXCLUSIVE: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !(rd_valid && rd_err)); // R11

  AST_GOOD_READ: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_ready && !rd_empty |=> rd_valid); // R11

  AST_EMPTY_READ_FLAG: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_ready && rd_empty |=> rd_err && !rd_valid && $stable(rd_data)); // R6

  AST_IDLE_HOLD: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_ready |=> !rd_valid && !rd_err && $stable(rd_data)); // R10

  AST_DROP_FLAG: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_valid && !wr_ready |=> wr_overflow); // R3

  AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_overflow |=> wr_overflow); // R3
endmodule

bind pxf_fifo pxf_fifo_chk #(.AW(AW), .DW(DW)) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_overflow(wr_overflow), .rd_clk(rd_clk), .rd_rst(rd_rst),
  .rd_ready(rd_ready), .rd_data(rd_data), .rd_valid(rd_valid),
  .rd_err(rd_err), .rd_empty(rd_empty), .rd_level(rd_level)
);

// File: tb/pxf_fifo_test.sv
module pxf_fifo_test;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int DEPTH = 32;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          wr_rst = 1'b1;
  logic          rd_rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_ready = 1'b0;
  logic          wr_ready, wr_overflow, rd_valid, rd_err, rd_empty, rd_cushion_ok;
  logic [DW-1:0] rd_data;
  logic [AW:0]   rd_level;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic [DW-1:0] model [$];

  always #10 wr_clk = ~wr_clk;   // 50 MHz
  always #7  rd_clk = ~rd_clk;

  pxf_fifo #(.AW(AW), .DW(DW), .CUSHION(2)) uut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_overflow(wr_overflow), .rd_clk(rd_clk),
    .rd_rst(rd_rst), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_err(rd_err), .rd_empty(rd_empty),
    .rd_level(rd_level), .rd_cushion_ok(rd_cushion_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 7 + 3);
  endfunction

  // called at a negedge of wr_clk; returns at the next one
  task automatic do_write(input logic [DW-1:0] d, output bit acc);
    wr_valid = 1'b1;
    wr_data  = d;
    acc      = wr_ready;
    if (acc) model.push_back(d);
    @(negedge wr_clk);
    wr_valid = 1'b0;
  endtask

  // called at a negedge of rd_clk; checks the beat one read clock later
  task automatic do_read();
    bit            was_empty;
    logic [DW-1:0] prev;
    logic [DW-1:0] exp;
    was_empty = rd_empty;
    prev      = rd_data;
    rd_ready  = 1'b1;
    @(negedge rd_clk);
    rd_ready  = 1'b0;
    if (was_empty) begin
      chk(rd_err === 1'b1 && rd_valid === 1'b0, "R6 flags", {rd_valid, rd_err}, 1);
      chk(rd_data === prev, "R6 data held", rd_data, prev);
    end else begin
      chk(rd_valid === 1'b1 && rd_err === 1'b0, "R11 flags", {rd_valid, rd_err}, 2);
      if (model.size() == 0) begin
        chk(1'b0, "R2 unexpected word", rd_data, -1);
      end else begin
        exp = model.pop_front();
        chk(rd_data === exp, "R2 order", rd_data, exp);
      end
    end
    chk(rd_level <= 6'(DEPTH), "R8 level bound", rd_level, DEPTH);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    if (!done) begin
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit acc;
    void'($urandom(32'd4711));
    repeat (4) @(negedge wr_clk);
    wr_rst = 1'b0;
    @(negedge rd_clk);
    rd_rst = 1'b0;
    repeat (3) @(negedge rd_clk);

    // R1 reset state
    chk(rd_empty === 1'b1, "R1 empty", rd_empty, 1);
    chk(rd_level === 0, "R1 level", rd_level, 0);
    chk(rd_cushion_ok === 1'b0, "R1 cushion", rd_cushion_ok, 0);
    chk(wr_ready === 1'b1 && wr_overflow === 1'b0, "R1 write side", {wr_ready, wr_overflow}, 2);
    chk(rd_valid === 1'b0 && rd_err === 1'b0, "R1 beat flags", {rd_valid, rd_err}, 0);

    // R6 read on a never-written FIFO
    do_read();
    // R10 idle cycles
    @(negedge rd_clk);
    chk(rd_valid === 1'b0 && rd_err === 1'b0, "R10 idle flags", {rd_valid, rd_err}, 0);

    // single word, then filler reads
    @(negedge wr_clk);
    do_write(8'hA5, acc);
    repeat (6) @(negedge rd_clk);
    chk(rd_level === 1, "R8 level one", rd_level, 1);
    chk(rd_cushion_ok === 1'b0, "R9 below cushion", rd_cushion_ok, 0);
    do_read();  // R7 first new word
    chk(rd_data === 8'hA5, "R7 first new word", rd_data, 8'hA5);
    chk(rd_empty === 1'b1, "R5 empty with last word", rd_empty, 1);
    do_read();  // R6 filler keeps A5
    do_read();
    chk(rd_data === 8'hA5, "R6 data after fillers", rd_data, 8'hA5);

    // fill to depth
    @(negedge wr_clk);
    for (int i = 0; i < DEPTH; i++) begin
      do_write(pat(i), acc);
      chk(acc, "R4 accepted", acc, 1);
    end
    repeat (8) @(negedge rd_clk);
    chk(wr_ready === 1'b0, "R4 full", wr_ready, 0);
    chk(rd_level === 6'(DEPTH), "R4 level full", rd_level, DEPTH);
    chk(rd_cushion_ok === 1'b1, "R9 cushion met", rd_cushion_ok, 1);
    @(negedge wr_clk);
    chk(wr_overflow === 1'b0, "R3 no overflow yet", wr_overflow, 0);
    do_write(8'hEE, acc);
    chk(!acc, "R3 dropped", acc, 0);
    chk(wr_overflow === 1'b1, "R3 overflow set", wr_overflow, 1);

    // drain, dropped word must never show
    @(negedge rd_clk);
    for (int i = 0; i < DEPTH; i++) begin
      do_read();
      if (i == DEPTH - 2) chk(rd_empty === 1'b0, "R5 not empty early", rd_empty, 0);
    end
    chk(rd_empty === 1'b1, "R5 empty at last word", rd_empty, 1);
    chk(rd_data === pat(DEPTH - 1), "R3 dropped word absent", rd_data, pat(DEPTH - 1));
    do_read();
    @(negedge wr_clk);
    do_write(8'h11, acc);
    do_write(8'h22, acc);
    repeat (6) @(negedge rd_clk);
    do_read();
    chk(rd_data === 8'h11, "R7 resume after empty", rd_data, 8'h11);
    do_read();
    chk(wr_overflow === 1'b1, "R3 overflow sticky", wr_overflow, 1);

    // random traffic on both clocks
    fork
      begin
        @(negedge wr_clk);
        for (int i = 0; i < 1500; i++) begin
          if ($urandom % 100 < 55) do_write(DW'($urandom), acc);
          else @(negedge wr_clk);
        end
      end
      begin
        @(negedge rd_clk);
        for (int i = 0; i < 2000; i++) begin
          if ($urandom % 100 < 50) do_read();
          else begin
            @(negedge rd_clk);
            chk(rd_valid === 1'b0 && rd_err === 1'b0, "R10 random idle", {rd_valid, rd_err}, 0);
          end
        end
      end
    join
    repeat (6) @(negedge rd_clk);
    for (int i = 0; i < 40; i++) do_read();
    chk(model.size() == 0, "R2 all words delivered", model.size(), 0);
    chk(rd_level === 0 && rd_empty === 1'b1, "R8 drained level", rd_level, 0);
    chk(rd_cushion_ok === 1'b0, "R9 drained cushion", rd_cushion_ok, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule